// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the word address for a synchronous memory that can run short bursts. A new external address is captured whenever either of two independent start strobes is high at a rising clock edge. After that, each edge that sees the advance input high moves the burst one step, and only the low offset bits change. Those bits follow either a linear count or an interleaved count. The upper address bits keep the value that was captured.

Bursting is optional. A controller may present a fresh address with a strobe on every cycle and take no penalty, or it may issue one strobe and then step through the burst with the advance input. The order-select input is treated as a static configuration pin. When it is low, which is its tie-off value, the count is interleaved. When it is high, the count is linear. There is no data stream through the block, so every pin is a plain control or address signal with no valid/ready handshake.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, addr_o is all zeros.
- R2: When start_a_i is high at a rising edge, addr_o equals the addr_i sampled at that edge, from that edge onward.
- R3: When start_b_i is high at a rising edge, addr_o equals the addr_i sampled at that edge, from that edge onward, independently of start_a_i.
- R4: With linear_i low (interleaved, the default tie-off), the low two bits of addr_o are the loaded offset XOR a two-bit step count. The step count is cleared by a load and incremented by each edge that has adv_i high and both strobes low. From offset 1 the sequence is 1,0,3,2.
- R5: With linear_i high, the low two bits of addr_o are (loaded offset + step count) mod 4. From offset 1 the sequence is 1,2,3,0.
- R6: Advancing never changes addr_o bits above bit 1. After four advances, the low bits return to the loaded offset.
- R7: If a strobe and adv_i are both high at the same edge, the address is reloaded from addr_i and the step count returns to zero.
- R8: An edge with both strobes and adv_i low leaves addr_o unchanged.
- R9: Loads on consecutive edges, through either strobe, each take effect with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External word address |
| start_a_i | input | 1 | First burst-start strobe, loads addr_i |
| start_b_i | input | 1 | Second burst-start strobe, loads addr_i |
| adv_i | input | 1 | Advance the burst by one step |
| linear_i | input | 1 | Count order: 0 interleaved, 1 linear |
| addr_o | output | ADDR_W | Current internal word address |

## Verification
Every result is due one rising edge after the inputs that cause it: a load, step or hold is visible on addr_o right after that edge. A change of linear_i alone shows at once, because it only remaps the stored offset and count. The bench drives inputs at the falling edge and pushes the expected address into a queue. A monitor pops and compares 2 ns after the next rising edge, so each comparison lands in the one cycle its stimulus affects. The reset value is checked directly before the first strobe is issued.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } bag_cmd_e;
endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
(
  input  logic     start_a_i,
  input  logic     start_b_i,
  input  logic     adv_i,
  output bag_cmd_e cmd_o
);
  // Either strobe takes priority over advance (R7).
  always_comb begin
    if (start_a_i || start_b_i) cmd_o = CMD_LOAD;
    else if (adv_i)             cmd_o = CMD_STEP;
    else                        cmd_o = CMD_HOLD;
  end
endmodule

// File: rtl/bag_count.sv
module bag_count
  import bag_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bag_cmd_e         cmd_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] start_o,
  output logic [OFS_W-1:0] cnt_o
);
  logic [OFS_W-1:0] start_q, cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          start_q <= ofs_i;
          cnt_q   <= '0;
        end
        CMD_STEP: cnt_q <= cnt_q + 1'b1;
        default:  ;
      endcase
    end
  end

  assign start_o = start_q;
  assign cnt_o   = cnt_q;

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP |=> cnt_q == OFS_W'($past(cnt_q) + 1'b1)); // R4
  AST_STEP_KEEPS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP |=> $stable(start_q)); // R6
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_LOAD |=> cnt_q == '0); // R7
endmodule

// File: rtl/bag_seq.sv
module bag_seq #(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] cnt_i,
  input  logic             linear_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] ilv, lin;

  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ cnt_i[b];
  end

  assign lin   = start_i + cnt_i;
  assign ofs_o = linear_i ? lin : ilv;

  always_comb begin
    if (cnt_i == '0) begin
      AST_FIRST_IS_START: assert (ofs_o == start_i); // R4
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_a_i,
  input  logic              start_b_i,
  input  logic              adv_i,
  input  logic              linear_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - OFS_W;

  bag_cmd_e         cmd;
  logic [OFS_W-1:0] start_ofs, cnt, ofs;
  logic [UP_W-1:0]  upper_q;

  bag_ctrl u_ctrl (
    .start_a_i(start_a_i), .start_b_i(start_b_i), .adv_i(adv_i), .cmd_o(cmd)
  );

  bag_count #(.OFS_W(OFS_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
    .ofs_i(addr_i[OFS_W-1:0]), .start_o(start_ofs), .cnt_o(cnt)
  );

  bag_seq #(.OFS_W(OFS_W)) u_seq (
    .start_i(start_ofs), .cnt_i(cnt), .linear_i(linear_i), .ofs_o(ofs)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          upper_q <= '0;
    else if (cmd == CMD_LOAD) upper_q <= addr_i[ADDR_W-1:OFS_W];
  end

  assign addr_o = {upper_q, ofs};

  AST_LOAD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_a_i |=> addr_o == $past(addr_i)); // R2
  AST_LOAD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_b_i |=> addr_o == $past(addr_i)); // R3
  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_a_i || start_b_i) |=> $stable(addr_o[ADDR_W-1:OFS_W])); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_a_i || start_b_i || adv_i) |=>
      (addr_o == $past(addr_o)) || (linear_i != $past(linear_i))); // R8
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 18;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          sa = 1'b0, sb = 1'b0, adv = 1'b0, lin = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_st = '0, m_cnt = '0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .OFS_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .start_a_i(sa),
    .start_b_i(sb), .adv_i(adv), .linear_i(lin), .addr_o(addr_o)
  );

  // Driver: applies one cycle of stimulus and predicts the address after the edge.
  task automatic step(input bit a, input bit b, input bit v,
                      input logic [AW-1:0] ad, input bit l, input string tag);
    logic [1:0] lo;
    @(negedge clk);
    sa = a; sb = b; adv = v; addr_i = ad; lin = l;
    if (a || b) begin
      m_up = ad[AW-1:2]; m_st = ad[1:0]; m_cnt = 2'd0;
    end else if (v) m_cnt = m_cnt + 2'd1;
    lo = l ? 2'(m_st + m_cnt) : (m_st ^ m_cnt);
    exp_q.push_back({m_up, lo});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (addr_o !== e) begin
          errors++;
          $display("FAIL %s: addr_o=%h expected %h", t, addr_o, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (addr_o !== '0) begin
      errors++; $display("FAIL R1: addr_o=%h expected 0 in reset", addr_o);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    checks++;
    if (addr_o !== '0) begin
      errors++; $display("FAIL R1: addr_o=%h expected 0 after reset", addr_o);
    end

    // R2 load then R4 interleaved walk, R6 wrap
    step(1, 0, 0, 18'h12345, 0, "R2");
    step(0, 0, 1, 18'h3ffff, 0, "R4");
    step(0, 0, 1, 18'h00000, 0, "R4");
    step(0, 0, 1, 18'h00000, 0, "R4");
    step(0, 0, 1, 18'h2aaaa, 0, "R6");
    // R8 hold
    step(0, 0, 0, 18'h15555, 0, "R8");
    step(0, 0, 0, 18'h00002, 0, "R8");
    // R3 load then R5 linear walk
    step(0, 1, 0, 18'h2abc1, 1, "R3");
    step(0, 0, 1, 18'h00000, 1, "R5");
    step(0, 0, 1, 18'h00000, 1, "R5");
    step(0, 0, 1, 18'h00000, 1, "R5");
    step(0, 0, 1, 18'h11111, 1, "R6");
    step(0, 0, 1, 18'h00000, 1, "R5");
    // R7 strobe wins over advance
    step(1, 0, 1, 18'h0f00e, 1, "R7");
    step(0, 0, 1, 18'h00000, 1, "R5");
    step(0, 1, 1, 18'h30003, 0, "R7");
    step(0, 0, 1, 18'h00000, 0, "R4");
    step(1, 1, 1, 18'h1dead, 0, "R7");
    // R9 back-to-back loads
    step(1, 0, 0, 18'h00004, 0, "R9");
    step(0, 1, 0, 18'h3fffb, 0, "R9");
    step(1, 0, 0, 18'h20001, 1, "R9");
    step(0, 1, 0, 18'h10002, 1, "R9");
    step(0, 0, 1, 18'h00000, 1, "R5");
    step(0, 0, 0, 18'h00000, 1, "R8");
    @(negedge clk); sa = 0; sb = 0; adv = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule